// File: doc/BRIEF.md
# Dual-Strobe EDO DRAM Device Control Model

This block is a synthesizable behavioural model of the control side of a small extended-data-out DRAM. It is meant to sit inside a testbench as the device that a memory controller under test talks to. A fast system clock samples the strobe pins: the row strobe, two byte-lane column strobes, write enable and output enable. Each clock the model finds the edges on these pins, decodes which kind of cycle is under way, and updates a small storage array and its output drivers. The tri-state data bus is modelled as a 16-bit output word with one enable per byte lane. The driving `inout` is left to the wrapper that instantiates the model.

The two column strobes act as one internal strobe. That strobe becomes active when the first lane strobe goes low and inactive only after the last one has gone high. A column strobe that is already low when the row strobe falls selects a refresh. In a refresh the row comes from an internal 9-bit counter and the address pins play no part. Read data follows the extended-data-out rule. It stays on the bus after the column strobe rises and changes only at the next column strobe fall. It is removed when output enable rises, or when both the row strobe and the column strobe are high. The array is reduced to `2**(ROW_BITS+COL_BITS)` words: the row and column fields are the low bits of the multiplexed address.

Top module: `edo_dram_model`

## Requirements
- R1: The internal column strobe is active from the first fall of either lane strobe until both lane strobes are high. A lane strobe that falls while the other is already low starts no new access: the column, the read word and the lane enables stay unchanged.
- R2: If either lane strobe is low when the row strobe falls, the model pulses `rfsh_pulse` for one cycle and sets `rfsh_row` to the internal counter value. The counter then advances by one and wraps from 511 to 0. The address pins are ignored.
- R3: During a CAS-before-RAS refresh that follows no pending read, neither byte enable is asserted.
- R4: A column strobe fall with `we_n` high, while a normal row is open, reads the word at index {row, column}. The row is `addr[ROW_BITS-1:0]` taken at the row strobe fall, and the column is `addr[COL_BITS-1:0]` taken at the column strobe fall. `dq_oe[0]` (bits 7:0) follows `lcas_n` and `dq_oe[1]` (bits 15:8) follows `ucas_n`, both as they were at that fall. The enables are asserted only while `oe_n` is low and `we_n` is high.
- R5: If `we_n` is low at the column strobe fall, the lanes whose strobe is low are written from `dq_in` (early write). No byte enable is asserted for the rest of that access, even with `oe_n` low.
- R6: If `we_n` falls while the column strobe is active in an access that began as a read, the lanes whose strobe is low at that moment are written (late write).
- R7: After a read, the word and its enables stay valid through a column strobe rise with the row strobe low, and change only at the next column strobe fall. They are cleared once the row strobe and both lane strobes are all high.
- R8: A rise of `oe_n` ends the pending read. No enable returns until the next reading column strobe fall, even if `oe_n` goes low again.
- R9: A row strobe fall with both lane strobes high opens a row that carries no data and gives no refresh pulse. It also leaves the refresh counter unchanged.
- R10: A refresh made by pulsing the row strobe while the column strobe stays low after a read (hidden refresh) keeps the read word and its enables on the bus.
- R11: After reset, both enables are low, `rfsh_pulse` is low and `rfsh_row` is 0. The counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (9) | Multiplexed row/column address |
| dq_in | input | DW (16) | Write data from the bus |
| dq_out | output | DW (16) | Read data to the bus |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 = bits 7:0 |
| rfsh_pulse | output | 1 | One-cycle pulse per CAS-before-RAS refresh |
| rfsh_row | output | RC_W (9) | Row used by the last such refresh |

## Verification
Four properties are checked on every cycle. The merged strobe never reports two falls in a row. The refresh counter steps by exactly one after each refresh. An early write or a refresh that holds no read keeps both enables low. A rise of output enable, or a hidden refresh, leaves the pending read in the state it must have. Other behaviour depends on the order of pin events across many cycles, and only the bench's scenarios and its per-clock reference model show it. This covers the data returned for an address, the byte-lane masks, extended hold across page cycles, late writes, the counter wrap, and the address being ignored during refresh.

// File: rtl/edo_pkg.sv
package edo_pkg;
  // Per-clock pin events seen by the control logic.
  typedef struct packed {
    logic cas_act;   // merged column strobe active now
    logic cas_fall;  // merged strobe became active this clock
    logic ras_fall;
    logic ras_rise;
    logic we_fall;
    logic oe_rise;
  } edo_evt_t;
endpackage

// File: rtl/edo_edge_det.sv
module edo_edge_det
  import edo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ras_n,
  input  logic     lcas_n,
  input  logic     ucas_n,
  input  logic     we_n,
  input  logic     oe_n,
  output edo_evt_t evt
);
  logic cas_now;
  logic ras_q, cas_q, we_q, oe_q;

  // first lane low activates, last lane high releases
  assign cas_now = ~lcas_n | ~ucas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b0;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_now;
      we_q  <= we_n;
      oe_q  <= oe_n;
    end
  end

  always_comb begin
    evt.cas_act  = cas_now;
    evt.cas_fall = cas_now & ~cas_q;
    evt.ras_fall = ~ras_n & ras_q;
    evt.ras_rise = ras_n & ~ras_q;
    evt.we_fall  = ~we_n & we_q;
    evt.oe_rise  = oe_n & ~oe_q;
  end

  // R1: a second lane falling never produces a fresh merged fall
  a_r1_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cas_fall |=> !evt.cas_fall);
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (inc) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count = cnt_q;

  // R2: each refresh advances the row counter by exactly one (wrapping)
  a_r2_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/edo_store.sv
module edo_store #(
  parameter int AW     = 7,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_be,
  input  logic [AW-1:0]           idx,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[idx] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= cells[idx];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DW       = 16,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 4,
  parameter int RC_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic [1:0]        dq_oe,
  output logic              rfsh_pulse,
  output logic [RC_W-1:0]   rfsh_row
);
  localparam int LANES  = 2;
  localparam int LANE_W = DW / LANES;
  localparam int AW     = ROW_BITS + COL_BITS;

  edo_evt_t evt;

  logic act_q, act_n, ref_q, ref_n, early_q, early_n, rdv_q, rdv_n;
  logic pulse_q, pulse_n;
  logic [LANES-1:0]    mask_q, mask_n, lane_low;
  logic [ROW_BITS-1:0] row_q, row_n;
  logic [COL_BITS-1:0] col_q, col_n;
  logic [RC_W-1:0]     rrow_q, rrow_n, rc_cnt;
  logic                inc, wr_en, rd_en, go;
  logic [AW-1:0]       acc_idx;

  edo_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .evt(evt)
  );

  edo_refresh_ctr #(.W(RC_W)) u_rctr (
    .clk(clk), .rst_n(rst_n), .inc(inc), .count(rc_cnt)
  );

  edo_store #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_be(lane_low), .idx(acc_idx),
    .wr_data(dq_in), .rd_en(rd_en), .rd_data(dq_out)
  );

  assign lane_low = ~{ucas_n, lcas_n};
  assign go       = act_q & ~ref_q;

  // cycle decode
  always_comb begin
    act_n   = act_q;
    ref_n   = ref_q;
    early_n = early_q;
    rdv_n   = rdv_q;
    mask_n  = mask_q;
    row_n   = row_q;
    col_n   = col_q;
    rrow_n  = rrow_q;
    pulse_n = 1'b0;
    inc     = 1'b0;
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    acc_idx = {row_q, col_q};

    if (evt.ras_fall) begin
      if (evt.cas_act) begin            // strobe already low: refresh
        inc     = 1'b1;
        pulse_n = 1'b1;
        rrow_n  = rc_cnt;
        ref_n   = 1'b1;
      end else begin                    // normal row open
        act_n   = 1'b1;
        row_n   = addr[ROW_BITS-1:0];
        early_n = 1'b0;
      end
    end
    if (evt.ras_rise) begin
      act_n = 1'b0;
      ref_n = 1'b0;
    end

    if (go && evt.cas_fall) begin
      col_n   = addr[COL_BITS-1:0];
      acc_idx = {row_q, addr[COL_BITS-1:0]};
      if (!we_n) begin                  // early write
        wr_en   = 1'b1;
        early_n = 1'b1;
        rdv_n   = 1'b0;
      end else begin                    // read
        rd_en   = 1'b1;
        mask_n  = lane_low;
        rdv_n   = 1'b1;
        early_n = 1'b0;
      end
    end else if (go && evt.we_fall && evt.cas_act && !early_q) begin
      wr_en = 1'b1;                     // late write
    end

    if (evt.oe_rise || (ras_n && !evt.cas_act)) rdv_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      ref_q   <= 1'b0;
      early_q <= 1'b0;
      rdv_q   <= 1'b0;
      mask_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      rrow_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      act_q   <= act_n;
      ref_q   <= ref_n;
      early_q <= early_n;
      rdv_q   <= rdv_n;
      mask_q  <= mask_n;
      row_q   <= row_n;
      col_q   <= col_n;
      rrow_q  <= rrow_n;
      pulse_q <= pulse_n;
    end
  end

  assign dq_oe      = mask_q & {LANES{rdv_q & ~oe_n & we_n}};
  assign rfsh_pulse = pulse_q;
  assign rfsh_row   = rrow_q;

  // R5: an early write access never drives the bus
  a_r5_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    early_q |-> dq_oe == 2'b00);

  // R3: a refresh with no pending read keeps the bus released
  a_r3_cbr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && !rdv_q) |-> dq_oe == 2'b00);

  // R8: output enable rising ends the pending read
  a_r8_oe_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |=> !rdv_q);

  // R10: hidden refresh keeps the read word on the bus
  a_r10_hidden_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.ras_fall && evt.cas_act && rdv_q && !oe_n) |=> rdv_q);
endmodule

// File: tb/tb_edo_dram_model.sv
module tb_edo_dram_model;
  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
  logic [8:0]  addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        rfsh_pulse;
  logic [8:0]  rfsh_row;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  edo_dram_model dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mm [128];
  bit  m_pras, m_pcas, m_pwe, m_poe;
  bit  m_act, m_ref, m_early, m_rdv, m_pulse;
  bit  [1:0]  m_mask;
  int         m_row, m_col, m_ctr, m_rrow;
  logic [15:0] m_data;

  task automatic m_write(input int idx);
    if (!lcas_n) mm[idx][7:0]  = dq_in[7:0];
    if (!ucas_n) mm[idx][15:8] = dq_in[15:8];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pras = 1; m_pcas = 0; m_pwe = 1; m_poe = 1;
      m_act = 0; m_ref = 0; m_early = 0; m_rdv = 0; m_pulse = 0;
      m_mask = 0; m_row = 0; m_col = 0; m_ctr = 0; m_rrow = 0;
    end else begin
      bit cas, cf, rf, rr, wf, orise, was_go, was_early;
      cas = !lcas_n || !ucas_n;
      cf = cas && !m_pcas;
      rf = !ras_n && m_pras;
      rr = ras_n && !m_pras;
      wf = !we_n && m_pwe;
      orise = oe_n && !m_poe;
      was_go = m_act && !m_ref;
      was_early = m_early;
      m_pulse = 0;
      if (rf) begin
        if (cas) begin
          m_pulse = 1; m_rrow = m_ctr; m_ctr = (m_ctr + 1) % 512; m_ref = 1;
        end else begin
          m_act = 1; m_row = int'(addr) % 8; m_early = 0;
        end
      end
      if (rr) begin m_act = 0; m_ref = 0; end
      if (was_go && cf) begin
        m_col = int'(addr) % 16;
        if (!we_n) begin
          m_write(m_row * 16 + m_col); m_early = 1; m_rdv = 0;
        end else begin
          m_data = mm[m_row * 16 + m_col]; m_mask = {!ucas_n, !lcas_n};
          m_rdv = 1; m_early = 0;
        end
      end else if (was_go && wf && cas && !was_early) begin
        m_write(m_row * 16 + m_col);
      end
      if (orise || (ras_n && !cas)) m_rdv = 0;
      m_pras = ras_n; m_pcas = cas; m_pwe = we_n; m_poe = oe_n;
    end
  end

  // per-clock comparison, a quarter period after the active edge
  always begin
    @(posedge clk);
    #(TCK/4);
    if (rst_n === 1'b1 && !done) begin
      logic [1:0] e_oe;
      e_oe = m_rdv ? (m_mask & {2{!oe_n && we_n}}) : 2'b00;
      chk("R4 model enables", {30'd0, dq_oe}, {30'd0, e_oe});
      if (e_oe[0]) chk("R7 model low byte", {24'd0, dq_out[7:0]}, {24'd0, m_data[7:0]});
      if (e_oe[1]) chk("R7 model high byte", {24'd0, dq_out[15:8]}, {24'd0, m_data[15:8]});
      chk("R2 model pulse", {31'd0, rfsh_pulse}, {31'd0, m_pulse});
      chk("R2 model row", {23'd0, rfsh_row}, m_rrow);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_row(input int r);
    addr = 9'(r); ras_n = 0; tick();
  endtask

  task automatic cas_dn(input int c, input bit lo, input bit hi);
    addr = 9'(c); lcas_n = !lo; ucas_n = !hi; tick();
  endtask

  task automatic close_all();
    lcas_n = 1; ucas_n = 1; tick();
    ras_n = 1; we_n = 1; oe_n = 0; tick(2);
  endtask

  task automatic early_wr(input int r, input int c, input logic [15:0] d,
                          input bit lo, input bit hi);
    open_row(r);
    we_n = 0; oe_n = 0; dq_in = d;
    cas_dn(c, lo, hi);
    tick();
    chk("R5 early write quiet", {30'd0, dq_oe}, 0);
    close_all();
  endtask

  task automatic rd(input int r, input int c, input logic [15:0] e,
                    input logic [1:0] eoe, input string req);
    open_row(r);
    we_n = 1; oe_n = 0;
    cas_dn(c, eoe[0], eoe[1]);
    chk(req, {30'd0, dq_oe}, {30'd0, eoe});
    chk(req, {16'd0, dq_out & {{8{eoe[1]}}, {8{eoe[0]}}}},
             {16'd0, e & {{8{eoe[1]}}, {8{eoe[0]}}}});
    close_all();
    chk(req, {30'd0, dq_oe}, 0);
  endtask

  task automatic cbr(input int exp_row, input string req);
    addr = 9'h1FF; lcas_n = 0; tick();
    ras_n = 0; addr = 9'h0AA; tick();
    chk(req, {31'd0, rfsh_pulse}, 1);
    chk(req, {23'd0, rfsh_row}, exp_row);
    chk("R3 refresh quiet", {30'd0, dq_oe}, 0);
    ras_n = 1; tick();
    lcas_n = 1; tick();
  endtask

  initial begin
    rst_n = 0; ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 0;
    addr = '0; dq_in = '0;
    tick(3);
    rst_n = 1;
    tick();
    // R11 reset state
    chk("R11 enables", {30'd0, dq_oe}, 0);
    chk("R11 pulse", {31'd0, rfsh_pulse}, 0);
    chk("R11 row", {23'd0, rfsh_row}, 0);

    // R5 early writes (full words and an upper-byte-only write)
    early_wr(1, 2, 16'hA5C3, 1, 1);
    early_wr(1, 5, 16'h1234, 1, 1);
    early_wr(2, 3, 16'hBEEF, 1, 1);
    early_wr(2, 3, 16'h7700, 0, 1);

    // R4 reads, both lanes and lower lane only
    rd(1, 2, 16'hA5C3, 2'b11, "R4 word read");
    rd(2, 3, 16'h77EF, 2'b11, "R4 byte-merged read");
    rd(1, 5, 16'h1234, 2'b01, "R4 lower lane read");
    rd(2, 3, 16'h77EF, 2'b10, "R4 upper lane read");

    // R7 extended hold across page cycles
    open_row(1); we_n = 1; oe_n = 0;
    cas_dn(2, 1, 1);
    lcas_n = 1; ucas_n = 1; addr = 9'd5; tick(2);
    chk("R7 hold enables", {30'd0, dq_oe}, 2'b11);
    chk("R7 hold data", {16'd0, dq_out}, 16'hA5C3);
    cas_dn(5, 1, 1);
    chk("R7 next column", {16'd0, dq_out}, 16'h1234);
    lcas_n = 1; ucas_n = 1; tick();
    ras_n = 1; tick();
    chk("R7 released", {30'd0, dq_oe}, 0);
    tick();

    // R1 merged strobe: second lane fall starts nothing
    open_row(1); we_n = 1; oe_n = 0;
    cas_dn(2, 1, 0);
    chk("R1 first lane", {30'd0, dq_oe}, 2'b01);
    addr = 9'd5; ucas_n = 0; tick();
    chk("R1 no new access data", {16'd0, dq_out}, 16'hA5C3);
    chk("R1 no new access lanes", {30'd0, dq_oe}, 2'b01);
    lcas_n = 1; tick(); lcas_n = 0; tick();
    chk("R1 refall while held", {16'd0, dq_out}, 16'hA5C3);
    close_all();

    // R8 output enable rise ends the read
    open_row(2); we_n = 1; oe_n = 0;
    cas_dn(3, 1, 1);
    chk("R8 read on", {30'd0, dq_oe}, 2'b11);
    oe_n = 1; tick();
    chk("R8 off", {30'd0, dq_oe}, 0);
    oe_n = 0; tick();
    chk("R8 stays off", {30'd0, dq_oe}, 0);
    close_all();

    // R6 late write
    open_row(2); we_n = 1; oe_n = 1;
    cas_dn(7, 1, 1);
    dq_in = 16'h5A5A; we_n = 0; tick();
    we_n = 1; tick();
    close_all();
    rd(2, 7, 16'h5A5A, 2'b11, "R6 late write readback");

    // R2/R3 refresh with ignored address
    cbr(0, "R2 first refresh");
    cbr(1, "R2 second refresh");

    // R9 RAS-only cycle
    open_row(3);
    chk("R9 no pulse", {31'd0, rfsh_pulse}, 0);
    chk("R9 quiet", {30'd0, dq_oe}, 0);
    close_all();
    cbr(2, "R9 counter unchanged");

    // R10 hidden refresh
    open_row(1); we_n = 1; oe_n = 0;
    cas_dn(2, 1, 1);
    ras_n = 1; tick();
    ras_n = 0; tick();
    chk("R10 pulse", {31'd0, rfsh_pulse}, 1);
    chk("R10 row", {23'd0, rfsh_row}, 3);
    chk("R10 enables kept", {30'd0, dq_oe}, 2'b11);
    chk("R10 data kept", {16'd0, dq_out}, 16'hA5C3);
    ras_n = 1; tick();
    close_all();

    // R2 counter wrap
    for (int k = 4; k < 511; k++) cbr(k, "R2 sweep");
    cbr(511, "R2 last row");
    cbr(0, "R2 wrap");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule